// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

A passive observer that sits beside the command bus of a two-bank synchronous DRAM. On every rising clock edge it decodes chip select, the three strobes, the bank select and address bit 10, and walks a small state machine for each bank. Each command is judged by the state of the bank it addresses and by the cycle gaps that still have to run down. Commands that act on the whole device (auto refresh, mode register load) are judged against every bank at once. The monitor never drives the memory. It only reports.

Any offending command produces a one-cycle `illegal` pulse on the following clock, with a two-bit reason. The monitor does not act on a rejected command, so the bank states go on following what a well-behaved device would do. Bursts that carry auto-precharge run to the end of their own path: for reads, burst then precharge then idle; for writes, burst then write recovery then precharge then idle. All timing windows and the burst length are parameters counted in clocks.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After reset every bank reads state 0 (idle), `mode_busy` is low, `illegal` is low and `reason` is 0.
- R2: Commands are taken from {cs_n,ras_n,cas_n,we_n} at the rising edge: 0111 NOP, 0110 burst stop, 0101 read, 0100 write, 0011 activate, 0010 precharge (a10=1 means all banks), 0001 refresh, 0000 mode load, cs_n=1 deselect. Bank b's state sits in bank_state[4b+3:4b]. `illegal` and `reason` are registered and appear one clock after the offending edge. Reason codes are 1 for a wrong state, 2 for an unmet gap and 3 for a device-wide command issued while a bank is busy.
- R3: An activate to an idle bank puts it in state 1 (activating). A command T_RCD clocks after the activate finds it in state 2 (row active). A read or write to a bank that is still activating is flagged 2.
- R4: A read or write to an idle bank is flagged 1. A second activate to a bank that is not idle is flagged 1.
- R5: Precharge to a bank in row active, read or write is flagged 2 when it comes fewer than T_RAS clocks after that bank's activate. Otherwise the bank enters state 9 (precharging) and becomes idle T_RP clocks later. While precharging, an activate is flagged 2 and a read, write or burst stop is flagged 1.
- R6: A read or write to a row-active bank starts a BURST_LEN-clock burst: state 3 (read) or 4 (write) when a10=0, state 5 or 6 when a10=1. A new read or write restarts the burst. A burst stop during a plain burst returns the bank to row active. A plain read returns to row active when its burst ends.
- R7: A plain write burst ends in state 7 (write recovery). The bank returns to row active T_DPL clocks later. A precharge during write recovery is flagged 2.
- R8: Any read, write, activate, precharge or burst stop to a bank in state 5, 6 or 8 is flagged 1. A read with auto-precharge goes to precharging when its burst ends. A write with auto-precharge goes to state 8 for T_DPL clocks and then to precharging.
- R9: A refresh or mode load with any bank not idle is flagged 3. A refresh with all banks idle puts every bank in state 10 for T_RC clocks. While refreshing, a bank command is flagged 1.
- R10: An accepted mode load raises `mode_busy` for T_MRD clocks. During that window any command other than NOP or deselect is flagged 1.
- R11: An activate that comes fewer than T_RRD clocks after an accepted activate to another bank is flagged 2.
- R12: When cke was low at the previous edge, the command is ignored: it raises no flag and changes no state.
- R13: A flagged command changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable as seen by the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Auto-precharge / all-bank flag |
| bank_state | output | (2^BA_W)*4 | Per-bank state codes, bank b in bits 4b+3:4b |
| mode_busy | output | 1 | Mode register load window in progress |
| illegal | output | 1 | One-cycle pulse for a rejected command |
| reason | output | 2 | Cause of the last rejection, 0 when none |

## Verification
The flag and reason for a command sampled at edge k are registered, so they are due just after edge k. Every timed state leaves at edge entry+T-1, which means the first command to see the next state is the one at edge entry+T. The bench moves one command per clock. For each command it queues the expected reason, and a monitor compares that reason at the falling edge that follows. Bank state checks are made at the same falling edge. Each scenario counts edges from the activate, read, write, precharge, refresh or mode load that opened the window, so a command placed one clock early or on time exposes any off-by-one error in a window.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    C_DESL, C_NOP, C_BST, C_READ, C_WRITE, C_ACT, C_PRE, C_REF, C_MRS
  } cmd_e;

  typedef enum logic [3:0] {
    BK_IDLE  = 4'd0,
    BK_ACTG  = 4'd1,
    BK_ROW   = 4'd2,
    BK_RD    = 4'd3,
    BK_WR    = 4'd4,
    BK_RDA   = 4'd5,
    BK_WRA   = 4'd6,
    BK_WREC  = 4'd7,
    BK_WRECA = 4'd8,
    BK_PRCH  = 4'd9,
    BK_RFSH  = 4'd10
  } bank_st_e;

  typedef enum logic [1:0] {
    RS_NONE   = 2'd0,
    RS_STATE  = 2'd1,
    RS_TIMING = 2'd2,
    RS_BUSY   = 2'd3
  } rsn_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // strobe pattern to command
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = C_DESL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = C_NOP;
        3'b110:  c = C_BST;
        3'b101:  c = C_READ;
        3'b100:  c = C_WRITE;
        3'b011:  c = C_ACT;
        3'b010:  c = C_PRE;
        3'b001:  c = C_REF;
        default: c = C_MRS;
      endcase
    end
    return c;
  endfunction

  function automatic logic is_bank_cmd(input cmd_e c);
    return (c == C_BST) || (c == C_READ) || (c == C_WRITE) ||
           (c == C_ACT) || (c == C_PRE);
  endfunction

  // verdict for a command addressed to one bank in state st
  function automatic rsn_e bank_rule(input bank_st_e st, input cmd_e c,
                                     input logic ras_ok, input logic rrd_ok);
    rsn_e r;
    r = RS_NONE;
    case (st)
      BK_IDLE: begin
        if (c == C_READ || c == C_WRITE) r = RS_STATE;
        else if (c == C_ACT && !rrd_ok)  r = RS_TIMING;
      end
      BK_ACTG: begin
        if (c == C_READ || c == C_WRITE) r = RS_TIMING;
        else                             r = RS_STATE;
      end
      BK_ROW, BK_RD, BK_WR: begin
        if (c == C_ACT)                  r = RS_STATE;
        else if (c == C_PRE && !ras_ok)  r = RS_TIMING;
      end
      BK_WREC: begin
        if (c == C_ACT)      r = RS_STATE;
        else if (c == C_PRE) r = RS_TIMING;
      end
      BK_PRCH: begin
        if (c == C_ACT)      r = RS_TIMING;
        else if (c != C_PRE) r = RS_STATE;
      end
      default: r = RS_STATE; // auto-precharge paths and refresh
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd,
  output logic vld
);

  logic cke_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev_q <= 1'b1;
    else        cke_prev_q <= cke;
  end

  assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign vld = cke_prev_q;

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int IDX       = 0,
  parameter int BA_W      = 1,
  parameter int CW        = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_DPL     = 2,
  parameter int T_RC      = 7,
  parameter int BURST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld,
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic            rrd_ok,
  input  logic            accept,
  input  logic            ref_go,
  output bank_st_e        st,
  output rsn_e            rsn,
  output logic            hit
);

  localparam logic [CW-1:0] RAS_L = CW'(T_RAS);

  bank_st_e        st_q, st_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [CW-1:0]   ras_q;
  logic            reload, act_go, ras_ok, timed;

  // cycles a state lasts before its timer moves it on
  function automatic logic [CW-1:0] dwell(input bank_st_e s);
    case (s)
      BK_ACTG:                        return CW'(T_RCD - 1);
      BK_RD, BK_WR, BK_RDA, BK_WRA:   return CW'(BURST_LEN - 1);
      BK_WREC, BK_WRECA:              return CW'(T_DPL - 1);
      BK_PRCH:                        return CW'(T_RP - 1);
      BK_RFSH:                        return CW'(T_RC - 1);
      default:                        return '0;
    endcase
  endfunction

  function automatic bank_st_e after_timer(input bank_st_e s);
    case (s)
      BK_ACTG, BK_RD, BK_WREC:  return BK_ROW;
      BK_WR:                    return BK_WREC;
      BK_RDA, BK_WRECA:         return BK_PRCH;
      BK_WRA:                   return BK_WRECA;
      default:                  return BK_IDLE;
    endcase
  endfunction

  assign hit    = vld && is_bank_cmd(cmd) &&
                  ((ba == BA_W'(IDX)) || (cmd == C_PRE && a10));
  assign ras_ok = (ras_q == RAS_L);
  assign rsn    = hit ? bank_rule(st_q, cmd, ras_ok, rrd_ok) : RS_NONE;
  assign timed  = (st_q != BK_IDLE) && (st_q != BK_ROW);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    reload = 1'b0;
    act_go = 1'b0;
    if (timed) begin
      if (cnt_q <= 1) begin
        st_n   = after_timer(st_q);
        reload = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
    if (ref_go && st_q == BK_IDLE) begin
      st_n   = BK_RFSH;
      reload = 1'b1;
    end
    if (accept && hit) begin
      case (cmd)
        C_ACT: begin
          st_n   = BK_ACTG;
          reload = 1'b1;
          act_go = 1'b1;
        end
        C_READ, C_WRITE: begin
          if (cmd == C_READ) st_n = a10 ? BK_RDA : BK_RD;
          else               st_n = a10 ? BK_WRA : BK_WR;
          reload = 1'b1;
        end
        C_PRE: begin
          if (st_q == BK_ROW || st_q == BK_RD || st_q == BK_WR) begin
            st_n   = BK_PRCH;
            reload = 1'b1;
          end
        end
        C_BST: begin
          if (st_q == BK_RD || st_q == BK_WR) begin
            st_n   = BK_ROW;
            reload = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (reload) cnt_n = dwell(st_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
      ras_q <= RAS_L;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      if (act_go)            ras_q <= CW'(1);
      else if (ras_q != RAS_L) ras_q <= ras_q + 1'b1;
    end
  end

  assign st = st_q;

  // R3: activating only ever resolves into row active
  a_r3_actg_exit: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == BK_ACTG |=> (st_q == BK_ACTG || st_q == BK_ROW));

  // R5: precharging only ever resolves into idle
  a_r5_prch_exit: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == BK_PRCH |=> (st_q == BK_PRCH || st_q == BK_IDLE));

  // R8: an auto-precharge path never lands back in row active
  a_r8_ap_path: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_RDA || st_q == BK_WRA || st_q == BK_WRECA)
      |=> (st_q != BK_ROW && st_q != BK_IDLE));

  // R13: a rejected activate does not move an idle bank
  a_r13_rejected_act: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd == C_ACT && !accept && st_q == BK_IDLE) |=> st_q == BK_IDLE);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdcmd_pkg::*;
#(
  parameter int BA_W      = 1,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 7,
  parameter int T_DPL     = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic                       a10,
  output logic [(1<<BA_W)*4-1:0]     bank_state,
  output logic                       mode_busy,
  output logic                       illegal,
  output logic [1:0]                 reason
);

  localparam int NB   = 1 << BA_W;
  localparam int MAXT = max2(max2(max2(T_RCD, T_RAS), max2(T_RP, T_RRD)),
                             max2(max2(T_RC, T_DPL), max2(T_MRD, BURST_LEN)));
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] RRD_L = CW'(T_RRD);

  cmd_e            cmd;
  logic            vld;
  bank_st_e        bst   [NB];
  rsn_e            brsn  [NB];
  logic [NB-1:0]   bhit;
  logic [NB-1:0]   rrd_ok;
  rsn_e            bank_rsn, final_rsn;
  logic            all_idle, any_rfsh, accept, ref_go, mrs_go;
  logic            mra_q;
  logic [CW-1:0]   mra_cnt_q;
  logic [CW-1:0]   rrd_q;
  logic [BA_W-1:0] last_act_q;
  logic            illegal_q;
  rsn_e            reason_q;

  sdcmd_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd),
    .vld   (vld)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign rrd_ok[g] = (rrd_q == RRD_L) || (last_act_q == BA_W'(g));
    sdcmd_bank #(
      .IDX(g), .BA_W(BA_W), .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_RP(T_RP), .T_DPL(T_DPL), .T_RC(T_RC), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (vld),
      .cmd    (cmd),
      .ba     (ba),
      .a10    (a10),
      .rrd_ok (rrd_ok[g]),
      .accept (accept),
      .ref_go (ref_go),
      .st     (bst[g]),
      .rsn    (brsn[g]),
      .hit    (bhit[g])
    );
    assign bank_state[g*4 +: 4] = bst[g];
  end

  // combine bank verdicts with the device-wide rules
  always_comb begin
    bank_rsn = RS_NONE;
    all_idle = 1'b1;
    any_rfsh = 1'b0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (brsn[i] != RS_NONE) bank_rsn = brsn[i];
      if (bst[i] != BK_IDLE)  all_idle = 1'b0;
      if (bst[i] == BK_RFSH)  any_rfsh = 1'b1;
    end
    final_rsn = RS_NONE;
    if (vld && cmd != C_DESL && cmd != C_NOP) begin
      if (mra_q)                             final_rsn = RS_STATE;
      else if (cmd == C_REF || cmd == C_MRS) begin
        if (any_rfsh)                        final_rsn = RS_STATE;
        else if (!all_idle)                  final_rsn = RS_BUSY;
      end else                               final_rsn = bank_rsn;
    end
  end

  assign accept = vld && (final_rsn == RS_NONE);
  assign ref_go = accept && (cmd == C_REF);
  assign mrs_go = accept && (cmd == C_MRS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mra_q      <= 1'b0;
      mra_cnt_q  <= '0;
      rrd_q      <= RRD_L;
      last_act_q <= '0;
      illegal_q  <= 1'b0;
      reason_q   <= RS_NONE;
    end else begin
      illegal_q <= vld && (final_rsn != RS_NONE);
      reason_q  <= final_rsn;
      if (mrs_go) begin
        mra_q     <= 1'b1;
        mra_cnt_q <= CW'(T_MRD - 1);
      end else if (mra_q) begin
        if (mra_cnt_q <= 1) mra_q <= 1'b0;
        else                mra_cnt_q <= mra_cnt_q - 1'b1;
      end
      if (accept && cmd == C_ACT) begin
        rrd_q      <= CW'(1);
        last_act_q <= ba;
      end else if (rrd_q != RRD_L) begin
        rrd_q <= rrd_q + 1'b1;
      end
    end
  end

  assign mode_busy = mra_q;
  assign illegal   = illegal_q;
  assign reason    = reason_q;

  // R12: a gated cycle never produces a flag
  a_r12_cke_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> !illegal_q);

  // R10: the mode load window only exists with every bank idle
  a_r10_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mra_q |-> all_idle);

  // R9: refresh is held by all banks together
  a_r9_rfsh_together: assert property (@(posedge clk) disable iff (!rst_n)
    (bst[0] == BK_RFSH) |-> (bst[NB-1] == BK_RFSH));

  // R2: a flag is always accompanied by a nonzero reason
  a_r2_flag_reason: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> (reason_q != RS_NONE));

endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;

  localparam int K_NOP = 0, K_BST = 1, K_RD = 2, K_WR = 3,
                 K_ACT = 4, K_PRE = 5, K_REF = 6, K_MRS = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [0:0] ba = 1'b0;
  logic       a10 = 1'b0;
  logic [7:0] bank_state;
  logic       mode_busy, illegal;
  logic [1:0] reason;

  int total = 0;
  int bad = 0;

  typedef struct {
    int    rsn;
    string tag;
  } exp_t;
  exp_t sbq[$];

  sdram_cmd_monitor uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .bank_state(bank_state), .mode_busy(mode_busy),
    .illegal(illegal), .reason(reason)
  );

  always #5 clk = ~clk;

  task automatic drive(input int k);
    cs_n = 1'b0;
    case (k)
      K_BST:   {ras_n, cas_n, we_n} = 3'b110;
      K_RD:    {ras_n, cas_n, we_n} = 3'b101;
      K_WR:    {ras_n, cas_n, we_n} = 3'b100;
      K_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      K_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      K_REF:   {ras_n, cas_n, we_n} = 3'b001;
      K_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
  endtask

  // one command per clock; expected reason queued for the monitor
  task automatic step(input int k, input int b, input logic ap,
                      input logic ck, input int exp_rsn, input string tag);
    exp_t it;
    drive(k);
    ba  = b[0];
    a10 = ap;
    cke = ck;
    it.rsn = exp_rsn;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    drive(K_NOP);
    a10 = 1'b0;
    cke = 1'b1;
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) step(K_NOP, 0, 1'b0, 1'b1, 0, tag);
  endtask

  task automatic chk_state(input int b, input int exp_st, input string tag);
    int act;
    act = int'(bank_state[b*4 +: 4]);
    total++;
    if (act != exp_st) begin
      bad++;
      $display("FAIL %s bank%0d state actual=%0d expected=%0d", tag, b, act, exp_st);
    end
  endtask

  task automatic chk_busy(input logic exp_b, input string tag);
    total++;
    if (mode_busy !== exp_b) begin
      bad++;
      $display("FAIL %s mode_busy actual=%0b expected=%0b", tag, mode_busy, exp_b);
    end
  endtask

  // scoreboard monitor
  always begin
    @(posedge clk);
    if (sbq.size() > 0) begin
      exp_t it;
      it = sbq.pop_front();
      @(negedge clk);
      total++;
      if (illegal !== (it.rsn != 0) || reason !== it.rsn[1:0]) begin
        bad++;
        $display("FAIL %s illegal/reason actual=%0b/%0d expected=%0b/%0d",
                 it.tag, illegal, reason, (it.rsn != 0), it.rsn);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_state(0, 0, "R1");
    chk_state(1, 0, "R1");
    chk_busy(1'b0, "R1");
    total++;
    if (illegal !== 1'b0 || reason !== 2'd0) begin
      bad++;
      $display("FAIL R1 illegal/reason actual=%0b/%0d expected=0/0", illegal, reason);
    end

    // e0..e2: activate timing (R3)
    step(K_ACT, 0, 0, 1, 0, "R3 act");      chk_state(0, 1, "R3");
    step(K_RD,  0, 0, 1, 2, "R3 early rd"); chk_state(0, 1, "R3");
    step(K_NOP, 0, 0, 1, 0, "R3");          chk_state(0, 2, "R3");
    // e3 second bank, e4 double activate (R4, R13)
    step(K_ACT, 1, 0, 1, 0, "R11 gap met");
    step(K_ACT, 0, 0, 1, 1, "R4 act in row"); chk_state(0, 2, "R13");
    // e5 early precharge, e6 legal (R5)
    step(K_PRE, 0, 0, 1, 2, "R5 tras");     chk_state(0, 2, "R13");
    step(K_PRE, 0, 0, 1, 0, "R5 pre");      chk_state(0, 9, "R5");
    step(K_RD,  0, 0, 1, 1, "R5 rd prch");
    step(K_ACT, 0, 0, 1, 2, "R5 act prch"); chk_state(0, 0, "R5");
    // e9 refresh with bank1 open (R9)
    step(K_REF, 0, 0, 1, 3, "R9 ref busy"); chk_state(1, 2, "R13");
    // e10.. bursts on bank1 (R6, R8)
    step(K_RD,  1, 0, 1, 0, "R6 rd");       chk_state(1, 3, "R6");
    step(K_WR,  1, 1, 1, 0, "R6 wra");      chk_state(1, 6, "R6");
    step(K_BST, 1, 0, 1, 1, "R8 bst wra");  chk_state(1, 6, "R8");
    nops(2, "R8");                          chk_state(1, 8, "R8");
    step(K_PRE, 1, 0, 1, 1, "R8 pre wreca"); chk_state(1, 9, "R8");
    nops(2, "R8");                          chk_state(1, 0, "R8");
    // e18, e19 tRRD (R11)
    step(K_ACT, 0, 0, 1, 0, "R11 act0");
    step(K_ACT, 1, 0, 1, 2, "R11 rrd");     chk_state(1, 0, "R11");
    // e20 cke low, e21 ignored read (R12)
    step(K_NOP, 0, 0, 0, 0, "R12 cke low");
    step(K_RD,  1, 0, 1, 0, "R12 gated");   chk_state(1, 0, "R12");
    // e22 write burst and recovery (R7)
    step(K_WR,  0, 0, 1, 0, "R6 wr");       chk_state(0, 4, "R6");
    nops(3, "R7");                          chk_state(0, 7, "R7");
    step(K_PRE, 0, 0, 1, 2, "R7 pre wrec"); chk_state(0, 2, "R7");
    // e27 read, e28 burst stop (R6)
    step(K_RD,  0, 0, 1, 0, "R6 rd");       chk_state(0, 3, "R6");
    step(K_BST, 0, 0, 1, 0, "R6 bst");      chk_state(0, 2, "R6");
    // e29 precharge all (R5)
    step(K_PRE, 1, 1, 1, 0, "R5 pall");     chk_state(0, 9, "R5"); chk_state(1, 0, "R5");
    nops(2, "R5");                          chk_state(0, 0, "R5");
    // e32 mode load (R10)
    step(K_MRS, 0, 0, 1, 0, "R10 mrs");     chk_busy(1'b1, "R10");
    step(K_ACT, 0, 0, 1, 1, "R10 act busy"); chk_busy(1'b0, "R10"); chk_state(0, 0, "R10");
    // e34 refresh (R9)
    step(K_REF, 0, 0, 1, 0, "R9 ref");      chk_state(0, 10, "R9"); chk_state(1, 10, "R9");
    step(K_ACT, 0, 0, 1, 1, "R9 act rfsh");
    nops(4, "R9");                          chk_state(0, 10, "R9");
    nops(1, "R9");                          chk_state(0, 0, "R9"); chk_state(1, 0, "R9");
    // e41, e42 mode load while open (R9)
    step(K_ACT, 0, 0, 1, 0, "R3 act");
    step(K_MRS, 0, 0, 1, 3, "R9 mrs busy");
    step(K_NOP, 0, 0, 1, 0, "R3");          chk_state(0, 2, "R3");
    // e44 read auto-precharge (R8)
    step(K_RD,  0, 1, 1, 0, "R8 rda");      chk_state(0, 5, "R8");
    step(K_WR,  0, 0, 1, 1, "R8 wr rda");
    nops(2, "R8");                          chk_state(0, 9, "R8");
    nops(2, "R8");                          chk_state(0, 0, "R8");
    step(K_WR,  0, 0, 1, 1, "R4 wr idle");  chk_state(0, 0, "R4");

    nops(2, "tail");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule